// File: doc/BRIEF.md
# Multi-Core Doorbell and Self-Signal Interrupt Unit

This unit gives every core in a cluster two inter-core interrupt kinds: a "remote" signal that any core can raise on any set of cores, and a "self" signal. Each core owns a pending bit and a mask bit for each kind. Every core has its own request port. Through that port it reaches its own state at fixed local offsets. Through fixed per-core windows, the same port can reach the state of any core.

A core learns of a signal by reading its event register. The read returns a typed event word for the first pending, unmasked kind, and it masks that kind at the same clock edge. Software then clears the pending bit and writes the mask-clear register to enable the kind again. When a hardware source holds a core's event register, that source has precedence, and the unit neither reports nor masks anything for that core. A level output per core goes high while any kind is pending and unmasked.

Top module: `ipi_unit`

## Requirements
- R1: After reset, no kind is pending on any core and both kinds are masked. A pending read returns 0x00000000, a mask read returns 0x80000001, and every ipi_irq bit is low.
- R2: The local offsets act on the requesting core: 0x2004 event, 0x2008 send, 0x200c pending-clear, 0x2024 mask-set, 0x2028 mask-clear. The window of core c sits at 0x5000 + (c << 7), with 0x08 pending-set, 0x0c pending-clear, 0x24 mask-set and 0x28 mask-clear. A window for a core number at or above N_CPU has no effect and reads as zero.
- R3: A write to send sets the remote pending bit of core c for every set data bit c below N_CPU. Data bits at or above N_CPU are ignored.
- R4: In the pending-clear, pending-set and mask registers, data bit 0 selects the remote kind and data bit 31 selects the self kind. A clear write resets the selected pending bits, and all other data bits are ignored.
- R5: Mask-set and mask-clear writes set and clear the selected mask bits. When a mask-set (including the masking done by an event read) and a mask-clear hit the same bit in the same cycle, the bit ends up masked.
- R6: A window pending-set write with bit 31 sets the self pending bit of the addressed core, and with bit 0 sets its remote pending bit.
- R7: An event read returns 0x00040001 for the remote kind and 0x00040002 for the self kind, or 0x00000000 when no kind is both pending and unmasked. The remote kind is reported before the self kind.
- R8: An event read that reports a kind masks that kind at the same edge and leaves its pending bit set.
- R9: While hw_busy[c] is high, an event read by core c returns zero and masks nothing.
- R10: A set and a clear of the same pending bit in the same cycle leave that bit pending.
- R11: ipi_irq[c] is high exactly while core c has a kind that is both pending and unmasked. It reflects a write from the cycle after that write.
- R12: Read data and rd_valid appear one cycle after a read request. Pending reads (0x200c or window 0x08/0x0c) and mask reads (0x2024/0x2028 or window 0x24/0x28) use the bit-0/bit-31 layout. Unmapped reads return zero, writes do not raise rd_valid, and writes to the event offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CPU | Per-core request strobe |
| req_write | input | N_CPU | Per-core write (1) or read (0) |
| req_addr | input | 16*N_CPU | Per-core byte address, core p in slice p |
| req_wdata | input | 32*N_CPU | Per-core write data |
| hw_busy | input | N_CPU | Hardware event holds the core's event register |
| rd_valid | output | N_CPU | Read data valid, one cycle after a read |
| rd_data | output | 32*N_CPU | Per-core read data |
| ipi_irq | output | N_CPU | Per-core pending-and-unmasked level |

## Verification
A pending or mask bit stored in the wrong state shows up in the next pending or mask read and in ipi_irq on the cycle after the write that caused it. A wrong automatic mask shows up when a second event read reports the same kind again, or when ipi_irq stays high after delivery. The bench sweeps every requester against every target in both address views. Because each write has its effect one cycle later, a wrong decode or a wrong merge of concurrent requests becomes visible on the very next read.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 32;
  localparam int WIN_CPU_W = 5;
  localparam int KINDS     = 2;
  localparam logic [15:0] EVT_TYPE_IPI = 16'd4;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_EVENT, ACC_SEND, ACC_SET, ACC_CLR, ACC_MSET, ACC_MCLR
  } acc_e;

  typedef struct packed {
    acc_e                 kind;
    logic                 win;
    logic [WIN_CPU_W-1:0] cpu;
  } acc_t;

  // Map a byte address to an access kind, view and window core number
  function automatic acc_t addr_decode(input logic [ADDR_W-1:0] a);
    acc_t r;
    r.kind = ACC_NONE;
    r.win  = 1'b0;
    r.cpu  = a[11:7];
    if (a[15:12] == 4'h2 && a[11:6] == 6'd0) begin
      case (a[5:0])
        6'h04:   r.kind = ACC_EVENT;
        6'h08:   r.kind = ACC_SEND;
        6'h0c:   r.kind = ACC_CLR;
        6'h24:   r.kind = ACC_MSET;
        6'h28:   r.kind = ACC_MCLR;
        default: r.kind = ACC_NONE;
      endcase
    end else if (a[15:12] == 4'h5) begin
      r.win = 1'b1;
      case (a[6:0])
        7'h08:   r.kind = ACC_SET;
        7'h0c:   r.kind = ACC_CLR;
        7'h24:   r.kind = ACC_MSET;
        7'h28:   r.kind = ACC_MCLR;
        default: r.kind = ACC_NONE;
      endcase
    end
    return r;
  endfunction

  // Data word -> kind bits: [0] remote, [1] self
  function automatic logic [KINDS-1:0] kind_bits(input logic [DATA_W-1:0] d);
    return {d[31], d[0]};
  endfunction

  function automatic logic [DATA_W-1:0] kind_word(input logic [KINDS-1:0] k);
    return {k[1], 30'd0, k[0]};
  endfunction

  // Remote kind wins over self kind
  function automatic logic [KINDS-1:0] first_live(input logic [KINDS-1:0] live);
    if (live[0]) return 2'b01;
    if (live[1]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] event_word(input logic [KINDS-1:0] pick);
    if (pick[0]) return {EVT_TYPE_IPI, 16'd1};
    if (pick[1]) return {EVT_TYPE_IPI, 16'd2};
    return '0;
  endfunction
endpackage

// File: rtl/ipi_port_decode.sv
`timescale 1ns/1ps
module ipi_port_decode
  import ipi_pkg::*;
#(
  parameter int N_CPU   = 4,
  parameter int PORT_ID = 0,
  localparam int CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int OPS_W  = KINDS * N_CPU
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [OPS_W-1:0]  set_o,
  output logic [OPS_W-1:0]  clr_o,
  output logic [OPS_W-1:0]  mset_o,
  output logic [OPS_W-1:0]  mclr_o,
  output logic              ev_rd_o,
  output acc_e              rd_kind_o,
  output logic [CPU_W-1:0]  rd_tgt_o
);
  acc_t             dec;
  logic [KINDS-1:0] kb;
  logic             in_range;
  int               tgt;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    dec       = addr_decode(addr_i);
    kb        = kind_bits(wdata_i);
    in_range  = dec.win ? (int'(dec.cpu) < N_CPU) : 1'b1;
    tgt       = dec.win ? int'(dec.cpu) : PORT_ID;
    set_o     = '0;
    clr_o     = '0;
    mset_o    = '0;
    mclr_o    = '0;
    ev_rd_o   = 1'b0;
    rd_kind_o = ACC_NONE;
    rd_tgt_o  = dec.win ? dec.cpu[CPU_W-1:0] : CPU_W'(PORT_ID);
    if (valid_i && in_range) begin
      if (write_i) begin
        case (dec.kind)
          ACC_SEND: for (int t = 0; t < N_CPU; t++) set_o[KINDS*t] = wdata_i[t];
          ACC_SET:  set_o[KINDS*tgt +: KINDS]  = kb;
          ACC_CLR:  clr_o[KINDS*tgt +: KINDS]  = kb;
          ACC_MSET: mset_o[KINDS*tgt +: KINDS] = kb;
          ACC_MCLR: mclr_o[KINDS*tgt +: KINDS] = kb;
          default:  ;
        endcase
      end else begin
        rd_kind_o = dec.kind;
        ev_rd_o   = (dec.kind == ACC_EVENT);
      end
    end
  end
endmodule

// File: rtl/ipi_event_pick.sv
`timescale 1ns/1ps
module ipi_event_pick
  import ipi_pkg::*;
(
  input  logic [KINDS-1:0]  pend_i,
  input  logic [KINDS-1:0]  mask_i,
  input  logic              hw_busy_i,
  input  logic              ev_rd_i,
  output logic [DATA_W-1:0] word_o,
  output logic [KINDS-1:0]  take_o
);
  logic [KINDS-1:0] pick;

  always_comb begin
    pick   = first_live(pend_i & ~mask_i);
    word_o = hw_busy_i ? '0 : event_word(pick);
    take_o = (ev_rd_i && !hw_busy_i) ? pick : '0;
  end
endmodule

// File: rtl/ipi_cpu_state.sv
`timescale 1ns/1ps
module ipi_cpu_state
  import ipi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KINDS-1:0] set_i,
  input  logic [KINDS-1:0] clr_i,
  input  logic [KINDS-1:0] mset_i,
  input  logic [KINDS-1:0] mclr_i,
  output logic [KINDS-1:0] pend_o,
  output logic [KINDS-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
      mask_o <= '1;
    end else begin
      pend_o <= (pend_o & ~clr_i) | set_i;
      mask_o <= (mask_o & ~mclr_i) | mset_i;
    end
  end
endmodule

// File: rtl/ipi_unit.sv
`timescale 1ns/1ps
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int N_CPU  = 4,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int OPS_W = KINDS * N_CPU
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CPU-1:0]         req_valid,
  input  logic [N_CPU-1:0]         req_write,
  input  logic [N_CPU*ADDR_W-1:0]  req_addr,
  input  logic [N_CPU*DATA_W-1:0]  req_wdata,
  input  logic [N_CPU-1:0]         hw_busy,
  output logic [N_CPU-1:0]         rd_valid,
  output logic [N_CPU*DATA_W-1:0]  rd_data,
  output logic [N_CPU-1:0]         ipi_irq
);
  logic [OPS_W-1:0]  set_p  [N_CPU];
  logic [OPS_W-1:0]  clr_p  [N_CPU];
  logic [OPS_W-1:0]  mset_p [N_CPU];
  logic [OPS_W-1:0]  mclr_p [N_CPU];
  logic              ev_rd  [N_CPU];
  acc_e              rd_kind[N_CPU];
  logic [CPU_W-1:0]  rd_tgt [N_CPU];
  logic [DATA_W-1:0] ev_word[N_CPU];
  logic [KINDS-1:0]  pend_q [N_CPU];
  logic [KINDS-1:0]  mask_q [N_CPU];

  // Named internal events, observed by the bound checker
  logic [OPS_W-1:0]  set_all, clr_all, mset_all, mclr_all;
  logic [OPS_W-1:0]  take_all, pend_all, mask_all;

  for (genvar p = 0; p < N_CPU; p++) begin : g_port
    logic [DATA_W-1:0] rd_val;
    logic              rd_v_q;
    logic [DATA_W-1:0] rd_d_q;

    ipi_port_decode #(.N_CPU(N_CPU), .PORT_ID(p)) dec_i (
      .valid_i  (req_valid[p]),
      .write_i  (req_write[p]),
      .addr_i   (req_addr[p*ADDR_W +: ADDR_W]),
      .wdata_i  (req_wdata[p*DATA_W +: DATA_W]),
      .set_o    (set_p[p]),
      .clr_o    (clr_p[p]),
      .mset_o   (mset_p[p]),
      .mclr_o   (mclr_p[p]),
      .ev_rd_o  (ev_rd[p]),
      .rd_kind_o(rd_kind[p]),
      .rd_tgt_o (rd_tgt[p])
    );

    always_comb begin
      case (rd_kind[p])
        ACC_EVENT:          rd_val = ev_word[p];
        ACC_SET, ACC_CLR:   rd_val = kind_word(pend_q[rd_tgt[p]]);
        ACC_MSET, ACC_MCLR: rd_val = kind_word(mask_q[rd_tgt[p]]);
        default:            rd_val = '0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_v_q <= 1'b0;
        rd_d_q <= '0;
      end else begin
        rd_v_q <= req_valid[p] & ~req_write[p];
        if (req_valid[p] && !req_write[p]) rd_d_q <= rd_val;
      end
    end

    assign rd_valid[p]                   = rd_v_q;
    assign rd_data[p*DATA_W +: DATA_W]   = rd_d_q;
  end

  // Merge requests from all ports; auto-masking joins the mask-set path
  always_comb begin
    set_all  = '0;
    clr_all  = '0;
    mset_all = take_all;
    mclr_all = '0;
    for (int p = 0; p < N_CPU; p++) begin
      set_all  = set_all  | set_p[p];
      clr_all  = clr_all  | clr_p[p];
      mset_all = mset_all | mset_p[p];
      mclr_all = mclr_all | mclr_p[p];
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    ipi_event_pick pick_i (
      .pend_i   (pend_q[c]),
      .mask_i   (mask_q[c]),
      .hw_busy_i(hw_busy[c]),
      .ev_rd_i  (ev_rd[c]),
      .word_o   (ev_word[c]),
      .take_o   (take_all[c*KINDS +: KINDS])
    );

    ipi_cpu_state st_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_all[c*KINDS +: KINDS]),
      .clr_i (clr_all[c*KINDS +: KINDS]),
      .mset_i(mset_all[c*KINDS +: KINDS]),
      .mclr_i(mclr_all[c*KINDS +: KINDS]),
      .pend_o(pend_q[c]),
      .mask_o(mask_q[c])
    );

    assign pend_all[c*KINDS +: KINDS] = pend_q[c];
    assign mask_all[c*KINDS +: KINDS] = mask_q[c];
    assign ipi_irq[c] = |(pend_q[c] & ~mask_q[c]);
  end
endmodule

// File: rtl/ipi_unit_chk.sv
`timescale 1ns/1ps
module ipi_unit_chk #(
  parameter int N_CPU = 4,
  localparam int W    = 2 * N_CPU
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CPU-1:0] req_valid,
  input logic [N_CPU-1:0] req_write,
  input logic [N_CPU-1:0] hw_busy,
  input logic [N_CPU-1:0] rd_valid,
  input logic [N_CPU-1:0] ipi_irq,
  input logic [W-1:0]     pend_all,
  input logic [W-1:0]     mask_all,
  input logic [W-1:0]     set_all,
  input logic [W-1:0]     clr_all,
  input logic [W-1:0]     mset_all,
  input logic [W-1:0]     mclr_all,
  input logic [W-1:0]     take_all
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend_all == '0 && mask_all == '1))
    else $error("R1 reset state");

  for (genvar i = 0; i < W; i++) begin : g_bit
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_all[i] |=> pend_all[i]) else $error("R10 set lost");
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all[i] && !set_all[i]) |=> !pend_all[i]) else $error("R4 clear lost");
    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all[i] && !set_all[i]) |=> $stable(pend_all[i])) else $error("R4 pending moved");
    assert_mask_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mset_all[i] |=> mask_all[i]) else $error("R5 mask-set lost");
    assert_unmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mclr_all[i] && !mset_all[i]) |=> !mask_all[i]) else $error("R5 mask-clear lost");
    assert_take_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take_all[i] |-> (pend_all[i] && !mask_all[i])) else $error("R8 took dead kind");
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    assert_take_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_all[2*c +: 2])) else $error("R7 two kinds taken");
    assert_other_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_all[2*c+1] |-> !(pend_all[2*c] && !mask_all[2*c])) else $error("R7 order");
    assert_hw_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hw_busy[c] |-> (take_all[2*c +: 2] == 2'b00)) else $error("R9 hw precedence");
    assert_take_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|take_all[2*c +: 2]) |-> ipi_irq[c]) else $error("R11 irq low on delivery");
    assert_rd_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[c] && !req_write[c]) |=> rd_valid[c]) else $error("R12 rd_valid missing");
    assert_rd_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[c] && !req_write[c]) |=> !rd_valid[c]) else $error("R12 rd_valid spurious");
  end
endmodule

bind ipi_unit ipi_unit_chk #(.N_CPU(N_CPU)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .hw_busy  (hw_busy),
  .rd_valid (rd_valid),
  .ipi_irq  (ipi_irq),
  .pend_all (pend_all),
  .mask_all (mask_all),
  .set_all  (set_all),
  .clr_all  (clr_all),
  .mset_all (mset_all),
  .mclr_all (mclr_all),
  .take_all (take_all)
);

// File: tb/ipi_unit_tb_top.sv
`timescale 1ns/1ps
module ipi_unit_tb_top;
  localparam int N = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0, req_write = '0, hw_busy = '0;
  logic [N*16-1:0] req_addr = '0;
  logic [N*32-1:0] req_wdata = '0;
  logic [N-1:0]    rd_valid, ipi_irq;
  logic [N*32-1:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_unit #(.N_CPU(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .hw_busy(hw_busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .ipi_irq(ipi_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input int p, input bit wr, input logic [15:0] a, input logic [31:0] d);
    req_valid[p] = 1'b1;
    req_write[p] = wr;
    req_addr[p*16 +: 16] = a;
    req_wdata[p*32 +: 32] = d;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    req_valid = '0;
    req_write = '0;
  endtask

  task automatic wr(input int p, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    put(p, 1'b1, a, d);
    step();
  endtask

  task automatic wr2(input int p1, input logic [15:0] a1, input logic [31:0] d1,
                     input int p2, input logic [15:0] a2, input logic [31:0] d2);
    @(negedge clk);
    put(p1, 1'b1, a1, d1);
    put(p2, 1'b1, a2, d2);
    step();
  endtask

  task automatic rd(input int p, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    put(p, 1'b0, a, '0);
    step();
    d = rd_data[p*32 +: 32];
  endtask

  function automatic logic [15:0] win(input int c, input logic [6:0] off);
    return 16'h5000 + 16'(c << 7) + 16'(off);
  endfunction

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", 32'(ipi_irq), 32'h0);
    for (int c = 0; c < N; c++) begin
      rd(c, 16'h200c, d); chk("R1 pending after reset", d, 32'h0);
      rd(c, 16'h2024, d); chk("R1 mask after reset", d, 32'h8000_0001);
    end

    // R2 R3 R4: send sweep, high send bits ignored, local clear
    for (int p = 0; p < N; p++) begin
      for (int t = 0; t < N; t++) begin
        wr(p, 16'h2008, (32'h1 << t) | 32'hFFFF_FFF0);
        for (int u = 0; u < N; u++) begin
          rd(p, win(u, 7'h08), d);
          chk("R3 send target pending", d, (u == t) ? 32'h1 : 32'h0);
        end
        wr(t, 16'h200c, 32'h0000_0001);
        rd(t, 16'h200c, d); chk("R4 local clear", d, 32'h0);
      end
    end

    // R6 R11 R5 R7 R8: self kind through windows
    for (int t = 0; t < N; t++) begin
      wr(0, win(t, 7'h08), 32'h8000_0000);
      rd(t, 16'h200c, d); chk("R6 self pending", d, 32'h8000_0000);
      chk("R11 masked no irq", 32'(ipi_irq[t]), 32'h0);
      wr(t, 16'h2028, 32'h8000_0000);
      chk("R11 irq after unmask", 32'(ipi_irq[t]), 32'h1);
      rd(t, 16'h2024, d); chk("R5 only self unmasked", d, 32'h0000_0001);
      rd(t, 16'h2004, d); chk("R7 self event word", d, 32'h0004_0002);
      chk("R8 irq low after delivery", 32'(ipi_irq[t]), 32'h0);
      rd(t, 16'h2024, d); chk("R8 auto mask", d, 32'h8000_0001);
      rd(t, 16'h200c, d); chk("R8 pending kept", d, 32'h8000_0000);
      wr((t + 1) % N, win(t, 7'h0c), 32'h8000_0000);
      rd(t, 16'h200c, d); chk("R4 window clear", d, 32'h0);
      rd(t, 16'h2004, d); chk("R7 empty event", d, 32'h0);
    end

    // R7 ordering: remote before self
    wr(1, win(2, 7'h08), 32'h8000_0001);
    wr(2, 16'h2028, 32'h8000_0001);
    rd(2, 16'h2004, d); chk("R7 remote first", d, 32'h0004_0001);
    rd(2, 16'h2004, d); chk("R7 self second", d, 32'h0004_0002);
    rd(2, 16'h2004, d); chk("R7 none third", d, 32'h0);
    wr(2, 16'h200c, 32'h8000_0001);

    // R9 hardware precedence
    wr(3, 16'h2008, 32'h2);
    wr(1, 16'h2028, 32'h1);
    hw_busy[1] = 1'b1;
    rd(1, 16'h2004, d); chk("R9 event blocked", d, 32'h0);
    rd(1, 16'h2024, d); chk("R9 no auto mask", d, 32'h8000_0000);
    chk("R9 irq still high", 32'(ipi_irq[1]), 32'h1);
    hw_busy[1] = 1'b0;
    rd(1, 16'h2004, d); chk("R9 event after release", d, 32'h0004_0001);
    wr(1, 16'h200c, 32'h1);

    // R10 set and clear in the same cycle
    wr2(0, 16'h2008, 32'h2, 1, 16'h200c, 32'h1);
    rd(1, 16'h200c, d); chk("R10 send beats clear", d, 32'h1);
    wr2(2, win(3, 7'h08), 32'h8000_0000, 3, 16'h200c, 32'h8000_0000);
    rd(3, 16'h200c, d); chk("R10 window set beats clear", d, 32'h8000_0000);

    // R5 mask-set beats mask-clear
    wr(1, 16'h2028, 32'h1);
    rd(1, 16'h2024, d); chk("R5 remote unmasked", d, 32'h8000_0000);
    wr2(0, win(1, 7'h24), 32'h1, 1, 16'h2028, 32'h1);
    rd(1, 16'h2024, d); chk("R5 mask-set wins", d, 32'h8000_0001);

    // R12 R2: ignored writes, unmapped reads, read timing
    for (int c = 0; c < N; c++) wr(0, win(c, 7'h0c), 32'h8000_0001);
    wr(0, 16'h2004, 32'hFFFF_FFFF);
    chk("R12 write no rd_valid", 32'(rd_valid), 32'h0);
    wr(1, win(5, 7'h08), 32'hFFFF_FFFF);
    wr(1, win(5, 7'h28), 32'hFFFF_FFFF);
    wr(2, 16'h2010, 32'hFFFF_FFFF);
    for (int c = 0; c < N; c++) begin
      rd(c, 16'h200c, d); chk("R12 pending untouched", d, 32'h0);
      rd(c, 16'h2028, d); chk("R12 mask untouched", d, 32'h8000_0001);
    end
    chk("R12 irq all low", 32'(ipi_irq), 32'h0);
    rd(3, 16'h3000, d); chk("R12 unmapped zero", d, 32'h0);
    chk("R12 rd_valid after read", 32'(rd_valid[3]), 32'h1);
    rd(0, win(6, 7'h24), d); chk("R2 out of range window zero", d, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule